// File: doc/BRIEF.md
# Serial-Memory Word Read Sequencer

This block fetches one 16-bit word from a 1024-byte configuration memory. The memory sits behind a single 32-bit control and status register. A requester hands the block a byte address. The block then carries out the whole register conversation on the requester's behalf:

1. It writes the address, shifted up by one bit, into the register.
2. It reads the register back and writes it again with the command bit cleared. This read-modify-write is what starts the memory access.
3. It polls the register at a fixed microsecond interval until the read-valid flag appears or a time budget runs out.
4. It returns the upper half of the register as the data word, or it signals an error.

Timing comes from a one-cycle `us_tick` pulse, so the interval does not depend on the clock frequency. The register side is a plain single-outstanding master: each access holds its request until the slave acknowledges it. For reads, the slave presents the data together with the acknowledge. A request outside the memory image is refused at once without touching the register.

Top module: `eeprom_word_reader`

## Requirements
- R1: A synchronous active-high reset returns the block to idle within one clock edge: `busy`, `rsp_done`, `rsp_error`, `reg_req` and `rsp_data` all read 0, even if a read was in progress.
- R2: An accepted request first issues a register write whose data is the byte address shifted left by one (address in bits 10..1, all other bits 0).
- R3: The second access is a register read. The third access is a write of exactly that read value with bit 1 (the command bit) cleared and every other bit unchanged.
- R4: Every later access is a poll read of the register. Before each poll, including the first, the block waits for POLL_US (10) `us_tick` pulses, counted after the previous access completes. Bit 0 of the returned value is the read-valid flag.
- R5: When a poll returns bit 0 set, the block pulses `rsp_done` for one cycle with `rsp_error` low. In that cycle `rsp_data` holds bits 31..16 of the polled value, and no further access follows.
- R6: After TIMEOUT_POLLS (500) polls without the valid flag, the block pulses `rsp_done` together with `rsp_error` for one cycle and issues no further access.
- R7: A request with byte address 1024 or above is refused. `rsp_done` and `rsp_error` pulse in the next cycle and no register access is made.
- R8: Only one register access is in flight at a time. `reg_req`, `reg_we` and `reg_wdata` stay unchanged from the cycle `reg_req` rises until the cycle `reg_ack` is seen.
- R9: `busy` is high from the cycle after a request is accepted until the completion pulse. While `busy` is high, `req_valid` is ignored, and no register access happens while `busy` is low.
- R10: `rsp_data` changes only in the cycle of a successful completion. Refusals and timeouts leave it at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | input | 1 | Start a word read (taken when idle) |
| req_addr | input | REQ_AW (16) | Byte address of the word |
| busy | output | 1 | A read is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | With `rsp_done`: refused or timed out |
| rsp_data | output | DATA_W (16) | Last successfully read word |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_wdata | output | REG_W (32) | Register write data |
| reg_rdata | input | REG_W (32) | Register read data, valid with `reg_ack` |
| reg_ack | input | 1 | Access completes in this cycle |

## Verification
The bound checker watches, on every cycle:
- the request-hold rule of the register port;
- the one-cycle completion pulse;
- that `rsp_data` moves only on a successful completion;
- that the register port stays quiet while idle;
- the refusal of out-of-range addresses;
- the contents of the first write after acceptance.

The bench's register model covers what only whole scenarios can show:
- the read-modify-write order and its preserved bits;
- the ten-tick spacing before every poll;
- success on the first, a middle and the 500th poll;
- the full timeout;
- requests ignored while busy;
- a reset in the middle of a read.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ADDR,
    ST_RD_CMD,
    ST_WR_CLR,
    ST_WAIT,
    ST_POLL
  } rd_state_t;

  localparam int CMD_BIT   = 1;
  localparam int VALID_BIT = 0;
endpackage

// File: rtl/eeprom_rd_interval_timer.sv
// Counts us_tick pulses while run is high; expire marks the TICKS-th one.
module eeprom_rd_interval_timer #(
  parameter int TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt;

  assign expire = run && tick && (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == CW'(TICKS - 1)) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_rd_poll_counter.sv
// Counts unanswered polls; last flags the final allowed one.
module eeprom_rd_poll_counter #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eeprom_rd_bus_master.sv
// Single-outstanding register master: latches an access on issue and
// holds it until the slave acknowledges.
module eeprom_rd_bus_master #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             issue_we,
  input  logic [REG_W-1:0] issue_wdata,
  output logic             reg_req,
  output logic             reg_we,
  output logic [REG_W-1:0] reg_wdata,
  input  logic             reg_ack,
  output logic             acc_done
);
  assign acc_done = reg_req && reg_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else if (issue) begin
      reg_req   <= 1'b1;
      reg_we    <= issue_we;
      reg_wdata <= issue_wdata;
    end else if (acc_done) begin
      reg_req   <= 1'b0;
    end
  end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
  import eeprom_rd_pkg::*;
#(
  parameter int REQ_AW        = 16,
  parameter int REG_W         = 32,
  parameter int DATA_W        = 16,
  parameter int IMAGE_BYTES   = 1024,
  parameter int POLL_US       = 10,
  parameter int TIMEOUT_POLLS = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              us_tick,
  input  logic              req_valid,
  input  logic [REQ_AW-1:0] req_addr,
  output logic              busy,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_data,
  output logic              reg_req,
  output logic              reg_we,
  output logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  reg_rdata,
  input  logic              reg_ack
);
  localparam logic [REG_W-1:0] CMD_MASK = REG_W'(1) << CMD_BIT;

  rd_state_t        state, nxt;
  logic             acc_done, expire, poll_last;
  logic             issue, issue_we;
  logic [REG_W-1:0] issue_wdata;
  logic             pc_clr, pc_inc;
  logic             reject, finish_ok, finish_err;
  logic             in_range;
  logic [REG_W-1:0] addr_word;

  assign in_range  = (32'(req_addr) < IMAGE_BYTES);
  assign addr_word = REG_W'(req_addr) << 1;

  eeprom_rd_bus_master #(.REG_W(REG_W)) u_bus (
    .clk(clk), .rst(rst),
    .issue(issue), .issue_we(issue_we), .issue_wdata(issue_wdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .acc_done(acc_done)
  );

  eeprom_rd_interval_timer #(.TICKS(POLL_US)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .tick(us_tick),
    .expire(expire)
  );

  eeprom_rd_poll_counter #(.LIMIT(TIMEOUT_POLLS)) u_polls (
    .clk(clk), .rst(rst), .clr(pc_clr), .inc(pc_inc), .last(poll_last)
  );

  always_comb begin
    nxt         = state;
    issue       = 1'b0;
    issue_we    = 1'b0;
    issue_wdata = '0;
    pc_clr      = 1'b0;
    pc_inc      = 1'b0;
    reject      = 1'b0;
    finish_ok   = 1'b0;
    finish_err  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (in_range) begin
            nxt         = ST_WR_ADDR;
            issue       = 1'b1;
            issue_we    = 1'b1;
            issue_wdata = addr_word;
            pc_clr      = 1'b1;
          end else begin
            reject = 1'b1;
          end
        end
      end
      ST_WR_ADDR: begin
        if (acc_done) begin
          nxt   = ST_RD_CMD;
          issue = 1'b1;
        end
      end
      ST_RD_CMD: begin
        if (acc_done) begin
          nxt         = ST_WR_CLR;
          issue       = 1'b1;
          issue_we    = 1'b1;
          issue_wdata = reg_rdata & ~CMD_MASK;
        end
      end
      ST_WR_CLR: begin
        if (acc_done) nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (expire) begin
          nxt   = ST_POLL;
          issue = 1'b1;
        end
      end
      ST_POLL: begin
        if (acc_done) begin
          if (reg_rdata[VALID_BIT]) begin
            finish_ok = 1'b1;
            nxt       = ST_IDLE;
          end else if (poll_last) begin
            finish_err = 1'b1;
            nxt        = ST_IDLE;
          end else begin
            pc_inc = 1'b1;
            nxt    = ST_WAIT;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      rsp_data  <= '0;
    end else begin
      state     <= nxt;
      busy      <= (nxt != ST_IDLE);
      rsp_done  <= reject || finish_ok || finish_err;
      rsp_error <= reject || finish_err;
      if (finish_ok) rsp_data <= reg_rdata[REG_W-1 -: DATA_W];
    end
  end
endmodule

// File: rtl/eeprom_word_reader_chk.sv
module eeprom_word_reader_chk #(
  parameter int REQ_AW      = 16,
  parameter int REG_W       = 32,
  parameter int DATA_W      = 16,
  parameter int IMAGE_BYTES = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [REQ_AW-1:0] req_addr,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_error,
  input logic [DATA_W-1:0] rsp_data,
  input logic              reg_req,
  input logic              reg_we,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              reg_ack
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_wdata)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_data != $past(rsp_data)) |-> (rsp_done && !rsp_error));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !reg_req);

  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && (32'(req_addr) >= IMAGE_BYTES))
      |=> (rsp_done && rsp_error && !reg_req));

  p_first_write_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && (32'(req_addr) < IMAGE_BYTES))
      |=> (reg_req && reg_we && (reg_wdata == (REG_W'($past(req_addr)) << 1))));
endmodule

bind eeprom_word_reader eeprom_word_reader_chk #(
  .REQ_AW(REQ_AW), .REG_W(REG_W), .DATA_W(DATA_W), .IMAGE_BYTES(IMAGE_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .busy(busy), .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_data(rsp_data),
  .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_ack(reg_ack)
);

// File: tb/eeprom_word_reader_tb_top.sv
module eeprom_word_reader_tb_top;
  localparam int POLL_US       = 10;
  localparam int TIMEOUT_POLLS = 500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        us_tick = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        busy, rsp_done, rsp_error;
  logic [15:0] rsp_data;
  logic        reg_req, reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic        reg_ack = 1'b0;

  always #5 clk = ~clk;

  eeprom_word_reader dut_i (
    .clk(clk), .rst(rst), .us_tick(us_tick), .req_valid(req_valid),
    .req_addr(req_addr), .busy(busy), .rsp_done(rsp_done),
    .rsp_error(rsp_error), .rsp_data(rsp_data), .reg_req(reg_req),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ack(reg_ack)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          err;
    logic [15:0] data;
    int          polls;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // register/memory model state
  int          phase = 4;     // 0 addr write, 1 rmw read, 2 clear write, 3 polls, 4 none
  int          mdl_k = 0;     // poll that returns valid (0 = never)
  logic [15:0] mdl_data = '0;
  logic [15:0] mdl_addr = '0;
  logic [31:0] rmw_val = '0;
  int          poll_n = 0;
  int          ticks_since = 0;
  int          n_access = 0;
  int          wait_c = 0;
  int          tick_div = 0;
  int          cyc = 0;
  logic [15:0] last_ok = '0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic service();
    int t;
    n_access++;
    t = ticks_since;
    ticks_since = 0;
    case (phase)
      0: begin
        check(reg_we && reg_wdata == ({16'b0, mdl_addr} << 1), "R2 address write",
              reg_wdata, {16'b0, mdl_addr} << 1);
        phase = 1;
      end
      1: begin
        check(!reg_we, "R3 second access is read", 32'(reg_we), 0);
        rmw_val   = 32'h5A00_F002 | ({16'b0, mdl_addr} << 1);
        reg_rdata = rmw_val;
        phase = 2;
      end
      2: begin
        check(reg_we && reg_wdata == (rmw_val & ~32'h2), "R3 command bit clear",
              reg_wdata, rmw_val & ~32'h2);
        phase = 3;
      end
      3: begin
        check(!reg_we, "R4 poll is read", 32'(reg_we), 0);
        check(t == POLL_US, "R4 poll interval ticks", t, POLL_US);
        poll_n++;
        if (poll_n == mdl_k) reg_rdata = {mdl_data, 16'h0101};
        else                 reg_rdata = {~mdl_data, 16'h0102};
      end
      default: check(1'b0, "R6/R7/R9 unexpected register access", n_access, 0);
    endcase
  endtask

  // single negedge process: tick source, register model, monitor, watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
      if (rst) begin
        reg_ack = 1'b0;
        wait_c  = 0;
        us_tick = 1'b0;
      end else begin
        tick_div = (tick_div + 1) % 4;
        us_tick  = (tick_div == 0);
        if (us_tick && !reg_req) ticks_since++;
        if (reg_ack) begin
          reg_ack = 1'b0;
        end else if (reg_req) begin
          if (wait_c >= (n_access % 3)) begin
            reg_ack = 1'b1;
            wait_c  = 0;
            service();
          end else begin
            wait_c++;
          end
        end
        if (rsp_done) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected completion", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(rsp_error == e.err, {e.tag, " error flag"}, 32'(rsp_error), 32'(e.err));
            check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
            check(poll_n == e.polls, {e.tag, " poll count"}, poll_n, e.polls);
            check(!busy, "R9 busy low at completion", 32'(busy), 0);
            phase = 4;
          end
        end
      end
    end
  end

  task automatic start_read(input logic [15:0] addr, input int k, input logic [15:0] d,
                            input bit err, input int polls, input string tag);
    exp_t e;
    @(negedge clk);
    mdl_addr = addr;
    mdl_k    = k;
    mdl_data = d;
    poll_n   = 0;
    phase    = (addr < 16'd1024) ? 0 : 4;
    e.err = err;
    e.data = err ? last_ok : d;
    e.polls = polls;
    e.tag = tag;
    exp_q.push_back(e);
    if (!err) last_ok = d;
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] addr, input int k, input logic [15:0] d,
                         input bit err, input int polls, input int accesses,
                         input string tag);
    int base;
    base = n_access;
    start_read(addr, k, d, err, polls, tag);
    wait_done();
    repeat (6) @(negedge clk);
    check(n_access - base == accesses, {tag, " access count"}, n_access - base, accesses);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !rsp_done && !rsp_error && !reg_req && rsp_data == 0,
          "R1 reset state", {busy, rsp_done, rsp_error, reg_req}, 0);

    // R5 success on first poll, lowest address
    do_read(16'd0, 1, 16'hBEEF, 1'b0, 1, 4, "R5 first-poll read");
    // R5 success on third poll, highest address
    do_read(16'd1023, 3, 16'h1234, 1'b0, 3, 6, "R5 top-address read");
    // R7 refusals
    do_read(16'd1024, 0, 16'h0, 1'b1, 0, 0, "R7 address 1024");
    do_read(16'hFFFF, 0, 16'h0, 1'b1, 0, 0, "R7 address FFFF");
    check(rsp_data == 16'h1234, "R10 data kept after refusal", rsp_data, 16'h1234);

    // R9 request while busy is ignored
    begin
      int base;
      base = n_access;
      start_read(16'd300, 4, 16'hA5A5, 1'b0, 4, "R9 busy read");
      repeat (20) @(negedge clk);
      check(busy, "R9 busy during read", 32'(busy), 1);
      req_valid = 1'b1;
      req_addr  = 16'd7;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      repeat (6) @(negedge clk);
      check(n_access - base == 7, "R9 ignored request access count", n_access - base, 7);
      check(rsp_data == 16'hA5A5, "R9 data from first request", rsp_data, 16'hA5A5);
    end

    // R6 timeout, data held (R10)
    do_read(16'd512, 0, 16'h7777, 1'b1, TIMEOUT_POLLS, TIMEOUT_POLLS + 3, "R6 timeout");
    check(rsp_data == 16'hA5A5, "R10 data kept after timeout", rsp_data, 16'hA5A5);
    // R4/R5 success on the very last allowed poll
    do_read(16'd2, TIMEOUT_POLLS, 16'h0F0F, 1'b0, TIMEOUT_POLLS, TIMEOUT_POLLS + 3,
            "R5 last-poll read");

    // R1 reset in the middle of a read
    start_read(16'd40, 0, 16'h0, 1'b1, 0, "R1 aborted");
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!busy && !rsp_done && !rsp_error && !reg_req && rsp_data == 0,
          "R1 reset mid-read", {busy, rsp_done, rsp_error, reg_req, 12'h0, rsp_data}, 0);
    exp_q.delete();
    phase   = 4;
    last_ok = '0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    do_read(16'd100, 2, 16'hC3C3, 1'b0, 2, 5, "R5 read after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule